// File: doc/BRIEF.md
# Banked Vector RAM Load Sequencer

This block lets a host fill a wide vector word one byte at a time through a single data port. Behind the port sit eleven byte-wide RAMs: ten hold pattern data and the last holds control data. A small bank counter picks which RAM a port write lands in. After each write the counter steps to the next RAM. After the write to the control RAM it emits a one-clock decrement strobe to an external vector address register and returns to its first code, ready for the next vector.

A control register sets the mode. In drive mode every RAM select is active at once, so the whole vector can be presented in parallel. In load mode exactly one select is active, the one the counter names. The same register holds an active-low init bit. While that bit is low, a read strobe on the data port re-seeds the counter to its first code.

The counter is four bits wide and its first code is 5, not 0. Codes 5 through 15 map to selects 0 through 10. The carry-out at code 15 drives both the decrement strobe and the reload.

Top module: `vload_seq`

## Requirements
- R1: After reset the block is in load mode with the init bit inactive (high), the counter holds 5, only `bank_sel_n[0]` is low, and `dec_n` is high.
- R2: A `ctl_wr` pulse captures `ctl_data[3]` as the mode (1 = drive, 0 = load) and `ctl_data[7]` as the active-low init bit. The new values take effect from the next cycle. All other data bits have no effect.
- R3: In drive mode all eleven bits of `bank_sel_n` are low at the same time.
- R4: In load mode exactly one bit of `bank_sel_n` is low, namely bit (count − 5).
- R5: A `port_wr` pulse in load mode at a count below 15 advances the count by one, so the low select moves up by one bit in the next cycle.
- R6: A `port_wr` pulse in load mode at count 15 reloads the count to 5. In the following cycle `dec_n` is low for exactly one clock.
- R7: A `port_rd` pulse while the init bit is low loads the count with 5. While the init bit is high, `port_rd` has no effect on the count.
- R8: In drive mode `port_wr` leaves the count unchanged and produces no decrement strobe.
- R9: When `port_rd` (with the init bit low) and `port_wr` arrive in the same cycle, the reload to 5 wins and no advance or decrement occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single synchronous clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | One-cycle strobe that writes the control register |
| ctl_data | input | 8 | Control data; bit 3 is the mode, bit 7 is the active-low init bit |
| port_rd | input | 1 | One-cycle read strobe on the RAM data port |
| port_wr | input | 1 | One-cycle write strobe on the RAM data port |
| bank_sel_n | output | 11 | Active-low RAM selects; bits 0 to 9 are pattern RAMs, bit 10 is the control RAM |
| dec_n | output | 1 | Active-low, one-clock decrement strobe for the vector address register |

## Verification
The assertions assume that `port_rd`, `port_wr` and `ctl_wr` are synchronous to `clk` and that each is a single-cycle pulse with no gaps inside a cycle. They also assume that the counter is only ever changed by the block itself, so it never leaves the range 5 to 15. The stimulus drives every strobe for exactly one cycle from the falling edge. Each access is followed by an idle cycle. Collisions are raised only on purpose, by pulsing read and write together in the one step that targets R9.

// File: rtl/vload_pkg.sv
// Package: shared types for the banked vector RAM load sequencer.
// Assumes: nothing beyond a single clock domain for all users.
package vload_pkg;

    // Operating mode held in the control register.
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_DRIVE = 1'b1
    } vmode_e;

endpackage : vload_pkg

// File: rtl/vload_ctl_reg.sv
// Module: vload_ctl_reg
// Holds the mode bit and the active-low init bit, both written by one host
// register strobe. Every other bit of the written byte is discarded.
// Assumes: ctl_wr is a single-cycle pulse synchronous to clk.
module vload_ctl_reg
    import vload_pkg::*;
#(
    parameter int CTL_W    = 8,
    parameter int MODE_BIT = 3,
    parameter int INIT_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_data,
    output vmode_e           mode,
    output logic             init_n
);

    // Capture mode and init bit on a host write; reset to load mode, init idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_LOAD;
            init_n <= 1'b1;
        end else if (ctl_wr) begin
            mode   <= vmode_e'(ctl_data[MODE_BIT]);
            init_n <= ctl_data[INIT_BIT];
        end
    end

    // R2: a host write lands the selected bits in the next cycle.
    p_ctl_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (mode == vmode_e'($past(ctl_data[MODE_BIT]))
                    && init_n == $past(ctl_data[INIT_BIT])));

    // R2: without a write, both bits hold.
    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ($stable(mode) && $stable(init_n)));

endmodule : vload_ctl_reg

// File: rtl/vload_bank_ctr.sv
// Module: vload_bank_ctr
// Bank counter that starts at PRESET and steps once per load-mode port write.
// At the last code a write reloads PRESET and produces a one-clock low
// strobe on dec_n. A port read while init_n is low re-seeds PRESET and
// takes priority over a write in the same cycle.
// Assumes: strobes are single-cycle pulses and the count starts in range.
module vload_bank_ctr
    import vload_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int PRESET    = 5,
    parameter int NUM_BANKS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vmode_e           mode,
    input  logic             init_n,
    input  logic             port_rd,
    input  logic             port_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             dec_n
);

    localparam logic [CNT_W-1:0] CODE_FIRST = CNT_W'(PRESET);
    localparam logic [CNT_W-1:0] CODE_LAST  = CNT_W'(PRESET + NUM_BANKS - 1);

    logic init_go;
    logic in_range;
    logic adv;
    logic wrap;

    // Classify this cycle's port access.
    always_comb begin
        init_go  = port_rd && !init_n;
        in_range = (cnt >= CODE_FIRST) && (cnt <= CODE_LAST);
        adv      = port_wr && (mode == MODE_LOAD) && in_range && !init_go;
        wrap     = adv && (cnt == CODE_LAST);
    end

    // Counter update: the init reload has priority, then the wrap, then the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CODE_FIRST;
        end else if (init_go || wrap) begin
            cnt <= CODE_FIRST;
        end else if (adv) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Decrement strobe: a registered, one-clock copy of the wrap event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_n <= 1'b1;
        end else begin
            dec_n <= !wrap;
        end
    end

    // R7: init read re-seeds the counter.
    p_init_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_go |=> (cnt == CODE_FIRST));

    // R5: an ordinary load-mode write steps by one.
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R6: a write at the last code reloads and strobes.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (!dec_n && cnt == CODE_FIRST));

    // R6: the strobe is exactly one clock wide.
    p_dec_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_n |=> dec_n);

    // R8: drive-mode writes neither move the count nor strobe.
    p_drive_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DRIVE && !init_go) |=> ($stable(cnt) && dec_n));

    // R9: a collision of init read and write yields a reload and no strobe.
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_go && port_wr) |=> (cnt == CODE_FIRST && dec_n));

endmodule : vload_bank_ctr

// File: rtl/vload_sel_dec.sv
// Module: vload_sel_dec
// Turns the bank count into active-low RAM selects. In drive mode every
// select is low; in load mode only the select for (cnt - PRESET) is low,
// and a count outside the bank range selects nothing.
// Assumes: purely combinational; the caller registers its inputs.
module vload_sel_dec
    import vload_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int PRESET    = 5,
    parameter int NUM_BANKS = 11
) (
    input  vmode_e               mode,
    input  logic [CNT_W-1:0]     cnt,
    output logic [NUM_BANKS-1:0] sel_n
);

    // One comparator per bank, each matching its own count code.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [CNT_W-1:0] CODE = CNT_W'(PRESET + g);
        assign sel_n[g] = !((mode == MODE_DRIVE) || (cnt == CODE));
    end

endmodule : vload_sel_dec

// File: rtl/vload_seq.sv
// Module: vload_seq (top)
// Steers host port writes across NUM_BANKS RAMs. Bank 0 is picked by count
// PRESET, and the last bank is the control RAM. After the control-RAM write
// it emits a one-clock decrement strobe and returns to bank 0.
// Assumes: all strobes are single-cycle pulses on clk; reset is synchronous.
module vload_seq
    import vload_pkg::*;
#(
    parameter int CTL_W     = 8,
    parameter int MODE_BIT  = 3,
    parameter int INIT_BIT  = 7,
    parameter int CNT_W     = 4,
    parameter int PRESET    = 5,
    parameter int NUM_BANKS = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic [CTL_W-1:0]     ctl_data,
    input  logic                 port_rd,
    input  logic                 port_wr,
    output logic [NUM_BANKS-1:0] bank_sel_n,
    output logic                 dec_n
);

    vmode_e           mode;
    logic             init_n;
    logic [CNT_W-1:0] cnt;

    // Host control register.
    vload_ctl_reg #(
        .CTL_W    (CTL_W),
        .MODE_BIT (MODE_BIT),
        .INIT_BIT (INIT_BIT)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .mode     (mode),
        .init_n   (init_n)
    );

    // Bank counter and decrement strobe.
    vload_bank_ctr #(
        .CNT_W     (CNT_W),
        .PRESET    (PRESET),
        .NUM_BANKS (NUM_BANKS)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .init_n  (init_n),
        .port_rd (port_rd),
        .port_wr (port_wr),
        .cnt     (cnt),
        .dec_n   (dec_n)
    );

    // Select decoder.
    vload_sel_dec #(
        .CNT_W     (CNT_W),
        .PRESET    (PRESET),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .mode  (mode),
        .cnt   (cnt),
        .sel_n (bank_sel_n)
    );

    // R3: drive mode selects every RAM.
    p_drive_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DRIVE) |-> (bank_sel_n == '0));

    // R4: load mode selects exactly one RAM, since the count never leaves range.
    p_load_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |-> ($countones(~bank_sel_n) == 1));

    // R6: while a strobe is out, the first bank is the one selected in load mode.
    p_dec_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_n && mode == MODE_LOAD) |-> (bank_sel_n[0] == 1'b0));

endmodule : vload_seq

// File: tb/test_vload_seq.sv
// Scoreboard bench: a driver task applies one access per step and pushes
// the expected outputs; a monitor pops and compares them at the falling edge.
module test_vload_seq;

    localparam int NB = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_data = '0;
    logic          port_rd = 1'b0;
    logic          port_wr = 1'b0;
    logic [NB-1:0] bank_sel_n;
    logic          dec_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Independent model of the requirements.
    int   m_cnt  = 5;
    logic m_mode = 1'b0;
    logic m_init = 1'b1;

    logic [NB-1:0] q_sel[$];
    logic          q_dec[$];
    string         q_tag[$];

    always #4 clk = ~clk;

    vload_seq i_vload_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_data   (ctl_data),
        .port_rd    (port_rd),
        .port_wr    (port_wr),
        .bank_sel_n (bank_sel_n),
        .dec_n      (dec_n)
    );

    function automatic logic [NB-1:0] exp_sel();
        if (m_mode) return '0;
        if (m_cnt >= 5 && m_cnt <= 15) return ~(NB'(1) << (m_cnt - 5));
        return '1;
    endfunction

    // Driver: one access, model update at the edge, expected item queued.
    task automatic step(input logic cw, input logic [7:0] cd,
                        input logic rd, input logic wr, input string tag);
        logic dec;
        @(negedge clk);
        ctl_wr = cw; ctl_data = cd; port_rd = rd; port_wr = wr;
        @(posedge clk);
        dec = 1'b1;
        if (rd && !m_init) m_cnt = 5;
        else if (wr && !m_mode && m_cnt >= 5) begin
            if (m_cnt == 15) begin m_cnt = 5; dec = 1'b0; end
            else m_cnt = m_cnt + 1;
        end
        if (cw) begin m_mode = cd[3]; m_init = cd[7]; end
        #1;
        q_sel.push_back(exp_sel());
        q_dec.push_back(dec);
        q_tag.push_back(tag);
        @(negedge clk);
        ctl_wr = 1'b0; port_rd = 1'b0; port_wr = 1'b0;
    endtask

    // Monitor: compare outputs against the queued expectations.
    always @(negedge clk) begin
        if (q_sel.size() > 0) begin
            logic [NB-1:0] es;
            logic          ed;
            string         t;
            es = q_sel.pop_front();
            ed = q_dec.pop_front();
            t  = q_tag.pop_front();
            n_checks++;
            if (bank_sel_n !== es || dec_n !== ed) begin
                n_fail++;
                $display("FAIL %s: sel=%b dec=%b expected sel=%b dec=%b",
                         t, bank_sel_n, dec_n, es, ed);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 8'h00, 0, 0, "R1 reset state");
        step(1, 8'h88, 0, 0, "R3 drive mode all selects");
        step(0, 8'h00, 0, 1, "R8 drive write no decrement");
        step(1, 8'h80, 0, 0, "R8 count held after drive writes");
        step(1, 8'h77, 0, 0, "R2 other bits ignored, init low");
        step(1, 8'hF7, 0, 0, "R2 load mode, init high");
        step(0, 8'h00, 0, 1, "R5 step to bank 1");
        step(0, 8'h00, 0, 1, "R4 one select at bank 2");
        step(0, 8'h00, 1, 0, "R7 read ignored with init high");
        step(1, 8'h00, 0, 0, "R2 init low");
        step(0, 8'h00, 1, 0, "R7 init read reloads");
        step(1, 8'h80, 0, 0, "R2 init high");
        for (int k = 0; k < 10; k++) step(0, 8'h00, 0, 1, "R5 walk banks");
        step(0, 8'h00, 0, 1, "R6 wrap at control RAM");
        step(0, 8'h00, 0, 0, "R6 strobe one clock wide");
        step(0, 8'h00, 0, 1, "R4 bank 1 after wrap");
        step(0, 8'h00, 0, 1, "R4 bank 2");
        step(1, 8'h00, 0, 0, "R2 init low again");
        step(0, 8'h00, 1, 1, "R9 read wins over write");
        step(1, 8'h80, 0, 0, "R9 count at first bank");
        for (int k = 0; k < 11; k++) step(0, 8'h00, 0, 1, "R6 second vector");
        step(1, 8'h08, 0, 0, "R3 drive after wrap");
        step(0, 8'h00, 0, 1, "R8 drive write again");
        step(1, 8'h80, 0, 0, "R8 count unchanged");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule : test_vload_seq